// File: doc/BRIEF.md
# Multi-Channel Repeat-Interrupt Down Timer

This block holds a small set of identical countdown channels behind one synchronous register port. Each channel runs from the system clock with no divider. It counts down from a programmed reload value, raises a flag when it reaches zero, and then either reloads and goes on (repeat) or stops (one-shot). The flags of all channels, each qualified by its own enable bit, are ORed onto a single interrupt line.

Software programs a channel by writing its reload value. If the top bit of that write is set, the value is also pushed into the counter at once, so the top bit works as a load command and never as data. Because of this, 31 bits remain for counting. The running count can be read at any time. Status flags are cleared by writing a one to them.

Top module: `rdt_timer`

## Requirements
- R1: After synchronous reset, every register of every channel reads zero and `irq` is low.
- R2: A channel whose counter is non-zero, and that has no reload write this cycle, decrements its counter by exactly one at each clock edge.
- R3: A reload write with bit 31 set loads bits 30:0 into the counter at that clock edge. Bit 31 is never stored, so the reload register reads back with bit 31 clear. A write of 0xFFFFFFFF gives a count of 0x7FFFFFFF.
- R4: When the counter steps from 1 to 0 the channel flag is set at the same edge. In repeat mode (control bits 2:1 equal to 0, and also the codes 2 and 3) the counter reloads from the reload register at the next edge, giving a period of reload+1 cycles.
- R5: In one-shot mode (control bits 2:1 equal to 1) the counter stays at zero after it expires and raises no further flags until a new reload value is written.
- R6: A reload write with bit 31 clear, made while the counter is non-zero, changes only the stored reload value, which is used at the next reload. If the counter is zero, the written value is loaded at that edge.
- R7: A channel whose reload value and counter are both zero stays at zero and never sets its flag.
- R8: Status bit 0 is the flag. Writing 1 to it clears it, and writing 0 leaves it unchanged. If the hardware sets the flag in the same cycle as a clearing write, the flag stays set.
- R9: `irq` is high exactly when at least one channel has both its flag and its enable (control bit 0) set.
- R10: Reads never change channel state, and writes to the count register are ignored.
- R11: Each channel takes 16 bytes, and the channel number is `bus_addr[7:4]`. Within a channel, `bus_addr[3:2]` selects 0 reload, 1 control, 2 count, 3 status. An access with `bus_addr[1:0]` non-zero, or to a channel number with no channel behind it, writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| irq | output | 1 | Shared interrupt, any enabled flag set |

## Verification
The embedded properties check on every cycle that each counter drops by exactly one, that a load command lands in the counter, that a flag rises only as its counter reaches zero, that an idle or halted one-shot channel stays put, that a hardware set beats a simultaneous clear, and that the interrupt never fires without a flag and an enable. Only the bench scenarios can show the full repeat period, the deferred effect of a plain reload write, one-shot restart, the address map including misaligned and unmapped accesses, and the read-only count register. For these the bench compares a behavioural model on every clock and also checks hand-computed values.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    // Register selector inside one channel's 16-byte window
    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_CTRL   = 2'd1,
        REG_COUNT  = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    // Channel run mode, control bits 2:1
    typedef enum logic [1:0] {
        MODE_REPEAT  = 2'd0,
        MODE_ONESHOT = 2'd1,
        MODE_RSV2    = 2'd2,
        MODE_RSV3    = 2'd3
    } run_mode_e;

    // Control register layout: {mode, enable}
    typedef struct packed {
        run_mode_e mode;
        logic      irq_en;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    // Per-channel write strobes produced by the decoder
    typedef struct packed {
        logic reload_we;
        logic ctrl_we;
        logic stat_we;
    } chan_wr_t;

    function automatic logic halts_at_zero(run_mode_e m);
        return m == MODE_ONESHOT;
    endfunction

endpackage

// File: rtl/rdt_decode.sv
module rdt_decode
    import rdt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output chan_wr_t [NUM_CH-1:0] wr_o,
    output logic [ADDR_W-5:0]     rd_ch_o,
    output reg_sel_e              rd_reg_o,
    output logic                  rd_hit_o
);
    localparam int CH_W = ADDR_W - 4;

    logic     aligned;
    logic     mapped;
    reg_sel_e sel;

    always_comb begin
        aligned  = (addr_i[1:0] == 2'b00);
        sel      = reg_sel_e'(addr_i[3:2]);
        rd_ch_o  = addr_i[ADDR_W-1:4];
        rd_reg_o = sel;
        mapped   = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i[ADDR_W-1:4] == CH_W'(c)) mapped = 1'b1;
        end
        rd_hit_o = aligned && mapped;
        for (int c = 0; c < NUM_CH; c++) begin
            wr_o[c].reload_we = we_i && aligned && (addr_i[ADDR_W-1:4] == CH_W'(c)) && (sel == REG_RELOAD);
            wr_o[c].ctrl_we   = we_i && aligned && (addr_i[ADDR_W-1:4] == CH_W'(c)) && (sel == REG_CTRL);
            wr_o[c].stat_we   = we_i && aligned && (addr_i[ADDR_W-1:4] == CH_W'(c)) && (sel == REG_STAT);
        end
    end

endmodule

// File: rtl/rdt_chan.sv
module rdt_chan
    import rdt_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_wr_t         wr_i,
    input  logic [CNT_W:0]   wdata_i,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] count_o,
    output chan_ctrl_t       ctrl_o,
    output logic             flag_o
);
    localparam int DW = CNT_W + 1;

    logic [CNT_W-1:0] reload_q, count_q, count_d;
    chan_ctrl_t       ctrl_q;
    logic             flag_q, flag_d;
    logic             load_cmd, load_now, expire, clr_req;

    always_comb begin
        load_cmd = wdata_i[DW-1];
        // A plain write to an idle counter starts it as well
        load_now = wr_i.reload_we && (load_cmd || count_q == '0);
        expire   = (count_q == CNT_W'(1)) && !load_now;
        clr_req  = wr_i.stat_we && wdata_i[0];

        if (load_now)
            count_d = wdata_i[CNT_W-1:0];
        else if (count_q != '0)
            count_d = count_q - CNT_W'(1);
        else if (!halts_at_zero(ctrl_q.mode))
            count_d = reload_q;
        else
            count_d = count_q;

        flag_d = expire | (flag_q & ~clr_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            flag_q  <= flag_d;
            if (wr_i.reload_we) reload_q <= wdata_i[CNT_W-1:0];
            if (wr_i.ctrl_we)   ctrl_q   <= chan_ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    assign reload_o = reload_q;
    assign count_o  = count_q;
    assign ctrl_o   = ctrl_q;
    assign flag_o   = flag_q;

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0 && !wr_i.reload_we) |=> count_q == $past(count_q) - CNT_W'(1)); // R2

    AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_i.reload_we && wdata_i[DW-1]) |=> count_q == $past(wdata_i[CNT_W-1:0])); // R3

    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> count_q == '0); // R4

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MODE_ONESHOT && count_q == '0 && !wr_i.reload_we) |=> count_q == '0); // R5

    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) |=> !$rose(flag_q)); // R7

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (expire && clr_req) |=> flag_q); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !expire) |=> !flag_q); // R8

endmodule

// File: rtl/rdt_irq.sv
module rdt_irq #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] flag_i,
    input  logic [NUM_CH-1:0] en_i,
    output logic              irq_o
);
    assign irq_o = |(flag_i & en_i);
endmodule

// File: rtl/rdt_timer.sv
module rdt_timer
    import rdt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W:0]    bus_wdata,
    output logic [CNT_W:0]    bus_rdata,
    output logic              irq
);
    localparam int DW   = CNT_W + 1;
    localparam int CH_W = ADDR_W - 4;

    chan_wr_t [NUM_CH-1:0] wr_v;
    logic [CH_W-1:0]       rd_ch;
    reg_sel_e              rd_reg;
    logic                  rd_hit;

    logic [CNT_W-1:0] reload_v [NUM_CH];
    logic [CNT_W-1:0] count_v  [NUM_CH];
    chan_ctrl_t       ctrl_v   [NUM_CH];
    logic [NUM_CH-1:0] flag_v, en_v;

    rdt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wr_o     (wr_v),
        .rd_ch_o  (rd_ch),
        .rd_reg_o (rd_reg),
        .rd_hit_o (rd_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        rdt_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_i     (wr_v[c]),
            .wdata_i  (bus_wdata),
            .reload_o (reload_v[c]),
            .count_o  (count_v[c]),
            .ctrl_o   (ctrl_v[c]),
            .flag_o   (flag_v[c])
        );
        assign en_v[c] = ctrl_v[c].irq_en;
    end

    rdt_irq #(.NUM_CH(NUM_CH)) u_irq (
        .flag_i (flag_v),
        .en_i   (en_v),
        .irq_o  (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_hit && rd_ch == CH_W'(c)) begin
                unique case (rd_reg)
                    REG_RELOAD: bus_rdata = {1'b0, reload_v[c]};
                    REG_CTRL:   bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_v[c]};
                    REG_COUNT:  bus_rdata = {1'b0, count_v[c]};
                    REG_STAT:   bus_rdata = {{(DW-1){1'b0}}, flag_v[c]};
                endcase
            end
        end
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flag_v == '0) |-> !irq); // R9

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_v != '0)); // R9

endmodule

// File: tb/rdt_timer_tb.sv
module rdt_timer_tb;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";
    logic [31:0] last_rd;
    logic        last_irq;

    int unsigned m_ival [N];
    int unsigned m_cnt  [N];
    bit [1:0]    m_mode [N];
    bit          m_en   [N];
    bit          m_flag [N];

    always #2 clk = ~clk;

    rdt_timer u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int ch = int'(a[7:4]);
        if (a[1:0] != 2'b00 || ch >= N) return 32'h0;
        case (a[3:2])
            2'd0: return m_ival[ch];
            2'd1: return {29'h0, m_mode[ch], m_en[ch]};
            2'd2: return m_cnt[ch];
            default: return {31'h0, m_flag[ch]};
        endcase
    endfunction

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int c = 0; c < N; c++) r |= (m_flag[c] & m_en[c]);
        return r;
    endfunction

    task automatic model_update(input bit we, input logic [7:0] a, input logic [31:0] d);
        int ch = int'(a[7:4]);
        bit ok = we && (a[1:0] == 2'b00);
        for (int c = 0; c < N; c++) begin
            bit iw, cw, sw, load, setf;
            int unsigned nc;
            iw = ok && ch == c && a[3:2] == 2'd0;
            cw = ok && ch == c && a[3:2] == 2'd1;
            sw = ok && ch == c && a[3:2] == 2'd3;
            load = iw && (d[31] || m_cnt[c] == 0);
            setf = (m_cnt[c] == 1) && !load;
            if (load)              nc = {1'b0, d[30:0]};
            else if (m_cnt[c] != 0) nc = m_cnt[c] - 1;
            else if (m_mode[c] != 2'd1) nc = m_ival[c];
            else                   nc = 0;
            m_flag[c] = setf | (m_flag[c] & !(sw && d[0]));
            if (iw) m_ival[c] = {1'b0, d[30:0]};
            if (cw) begin
                m_mode[c] = d[2:1];
                m_en[c]   = d[0];
            end
            m_cnt[c] = nc;
        end
    endtask

    task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        last_rd  = bus_rdata;
        last_irq = irq;
        chk({cur_req, " model read"}, bus_rdata, model_read(a));
        chk({cur_req, " model irq"}, {31'h0, irq}, {31'h0, model_irq()});
        @(posedge clk);
        #1;
        model_update(we, a, d);
    endtask

    task automatic rd(input logic [7:0] a);
        step(1'b0, a, 32'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            m_ival[c] = 0; m_cnt[c] = 0; m_mode[c] = 0; m_en[c] = 0; m_flag[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        for (int a = 0; a < 32; a += 4) begin
            rd(8'(a));
            chk("R1 reset read", last_rd, 32'h0);
        end
        chk("R1 irq low", {31'h0, last_irq}, 32'h0);

        // R2, R3, R4: repeat mode on channel 0
        cur_req = "R4";
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h8000_0005);
        for (int i = 0; i < 6; i++) begin
            rd(8'h08);
            chk("R2 countdown", last_rd, 32'(5 - i));
        end
        rd(8'h08);
        chk("R4 reload after zero", last_rd, 32'h5);
        rd(8'h0C);
        chk("R4 flag set", last_rd, 32'h1);
        chk("R9 irq with enable", {31'h0, last_irq}, 32'h1);

        // R8: write zero, collision, then clear
        cur_req = "R8";
        wr(8'h0C, 32'h0);
        rd(8'h0C);
        chk("R8 write zero keeps flag", last_rd, 32'h1);
        wr(8'h0C, 32'h1);          // counter at 1 here: set wins
        rd(8'h0C);
        chk("R8 hw set wins", last_rd, 32'h1);
        wr(8'h0C, 32'h1);
        rd(8'h0C);
        chk("R8 w1c clears", last_rd, 32'h0);
        chk("R9 irq low after clear", {31'h0, last_irq}, 32'h0);
        rd(8'h00);
        chk("R3 bit31 not stored", last_rd, 32'h5);

        // R9: flag without enable
        cur_req = "R9";
        wr(8'h04, 32'h0);
        for (int i = 0; i < 8; i++) rd(8'h08);
        rd(8'h0C);
        chk("R9 flag set", last_rd, 32'h1);
        chk("R9 no irq when disabled", {31'h0, last_irq}, 32'h0);

        // R6: plain write to running counter
        cur_req = "R6";
        while (m_cnt[0] != 3) rd(8'h08);
        wr(8'h00, 32'h0000_0009);
        rd(8'h08);
        chk("R6 count unaffected", last_rd, 32'h2);
        rd(8'h08); rd(8'h08);
        rd(8'h08);
        chk("R6 new value at reload", last_rd, 32'h9);

        // R7: zero interval idles
        cur_req = "R7";
        wr(8'h00, 32'h8000_0000);
        wr(8'h0C, 32'h1);
        wr(8'h04, 32'h1);
        for (int i = 0; i < 20; i++) begin
            rd(8'h08);
            chk("R7 idle count", last_rd, 32'h0);
        end
        rd(8'h0C);
        chk("R7 no flag", last_rd, 32'h0);

        // R5: one-shot on channel 1
        cur_req = "R5";
        wr(8'h14, 32'h3);
        wr(8'h10, 32'h8000_0004);
        for (int i = 0; i < 15; i++) rd(8'h18);
        chk("R5 halted at zero", last_rd, 32'h0);
        rd(8'h1C);
        chk("R5 flag once", last_rd, 32'h1);
        wr(8'h1C, 32'h1);
        for (int i = 0; i < 10; i++) rd(8'h18);
        rd(8'h1C);
        chk("R5 no second flag", last_rd, 32'h0);
        wr(8'h10, 32'h0000_0002);
        rd(8'h18);
        chk("R6 plain write restarts idle", last_rd, 32'h2);
        for (int i = 0; i < 6; i++) rd(8'h18);
        chk("R5 halted again", last_rd, 32'h0);

        // R3: maximum count
        cur_req = "R3";
        wr(8'h14, 32'h1);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10);
        chk("R3 max reload readback", last_rd, 32'h7FFF_FFFF);
        rd(8'h18);
        chk("R3 max count", last_rd, 32'h7FFF_FFFE);
        wr(8'h10, 32'h8000_0000);
        wr(8'h1C, 32'h1);

        // R4: reserved mode code behaves as repeat
        cur_req = "R4";
        wr(8'h04, 32'h5);
        wr(8'h00, 32'h8000_0003);
        for (int i = 0; i < 4; i++) rd(8'h08);
        rd(8'h08);
        chk("R4 mode 2 reloads", last_rd, 32'h3);

        // R10: count register is read-only
        cur_req = "R10";
        wr(8'h08, 32'h0000_0055);
        rd(8'h08);
        chk("R10 count write ignored", last_rd, 32'h1);

        // R11: address map edges
        cur_req = "R11";
        rd(8'h20);
        chk("R11 unmapped reads zero", last_rd, 32'h0);
        wr(8'h20, 32'h8000_0007);
        rd(8'h28);
        chk("R11 unmapped count zero", last_rd, 32'h0);
        wr(8'h01, 32'h8000_0009);
        rd(8'h00);
        chk("R11 misaligned write ignored", last_rd, 32'h3);
        rd(8'h03);
        chk("R11 misaligned read zero", last_rd, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule